// File: doc/BRIEF.md
# Precision-Scalable Signed Multiplier

This block multiplies two signed 16-bit two's-complement operands. It builds its partial products on the Baugh-Wooley scheme. The bits in which exactly one operand sign bit takes part are inverted, and two constant ones are added at columns `W` and `2W-1`. Only unsigned adds are then needed, and no sign extension of the rows is required. The result is always 32 bits wide.

A precision select, `half_prec`, picks the operation:

- **Full precision.** The block computes the full 16x16 product.
- **Half precision.** Only the upper byte of each operand is used. Before the array, the lower byte of each operand is forced to zero. The adders in the low columns therefore see no transitions. The 8x8 signed product appears in `product[31:16]`, and `product[15:0]` reads zero.

The precision select is sampled together with the operands, so every accepted operation carries its own mode.

A parameter `REG_OUT` adds one output register. The register is controlled by a two-state machine:

- `ST_IDLE`: no result was accepted in the last cycle.
- `ST_VALID`: a result was captured in the last cycle.

The machine has two transitions:

- `ST_IDLE`/`ST_VALID` → `ST_VALID` when `in_valid` is high.
- `ST_IDLE`/`ST_VALID` → `ST_IDLE` when `in_valid` is low.

`out_valid` is high exactly in `ST_VALID`. The product register loads only when `in_valid` is high and otherwise keeps its value. With `REG_OUT=0`, the result and the valid signal pass through combinationally.

Top module: `prec_scalable_mul`

## Requirements
- R1: With `half_prec`=0, `product` equals the signed product of `op_a` and `op_b` as a 32-bit two's-complement value.
- R2: With `half_prec`=1, `product` equals the signed product of `op_a[15:8]` and `op_b[15:8]`, multiplied by 65536. `product[15:0]` is zero, and the values of `op_a[7:0]` and `op_b[7:0]` have no effect on the result.
- R3: Both most-negative cases give 0x40000000 with no overflow: -32768 times -32768 in full precision, and -128 times -128 in half precision.
- R4: The precision select is taken together with the operands on each accepted input. Back-to-back operations in alternating modes each give the result of their own mode.
- R5: With `REG_OUT`=1, `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low after a cycle in which it was low.
- R6: While `in_valid` is low, `product` keeps its last value, even when the operands and the mode change.
- R7: While `rst_n` is low, `out_valid` is 0 and `product` is 0.
- R8: Mixed-sign operands, zero operands and a unit operand give correct signed results in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are presented |
| half_prec | input | 1 | 1 = 8-bit mode on upper bytes, 0 = 16-bit mode |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| out_valid | output | 1 | Product is valid |
| product | output | 32 | Signed product |

## Verification
The bench drives the two most-negative operand pairs. An array that mishandled the correction constants or the sign rows would return a negative or wrapped value there instead of 0x40000000.

In half precision it loads nonzero, varying low bytes. Incomplete gating would then leak into `product[15:0]` or shift the upper half.

Back-to-back operations with alternating modes expose a design that latched the mode late or sampled it from the wrong cycle. Idle cycles with changing inputs expose an output register that loads without `in_valid`.

// File: rtl/mul_pkg.sv
package mul_pkg;
    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_t;
endpackage

// File: rtl/mul_opgate.sv
module mul_opgate #(
    parameter int W = 16
) (
    input  logic         half_prec,
    input  logic [W-1:0] op_in,
    output logic [W-1:0] op_out
);
    localparam int LOW_W = W / 2;

    // Low half is held at zero in reduced precision so low adders stay quiet.
    always_comb begin
        op_out = op_in;
        if (half_prec) begin
            op_out[LOW_W-1:0] = '0;
        end
    end
endmodule

// File: rtl/mul_bw_array.sv
module mul_bw_array #(
    parameter int W = 16
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] CORR = (PW'(1) << W) | (PW'(1) << (PW - 1));

    logic [PW-1:0] row_v [W];
    logic [PW-1:0] acc   [W+1];

    assign acc[0] = CORR;

    for (genvar j = 0; j < W; j++) begin : g_row
        logic [W-1:0] pp;
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Exactly one sign bit involved: complemented (NAND form).
            if ((i == W - 1) != (j == W - 1)) begin : g_inv
                assign pp[i] = ~(mcand[i] & mplier[j]);
            end else begin : g_pos
                assign pp[i] = mcand[i] & mplier[j];
            end
        end
        assign row_v[j]  = PW'(pp) << j;
        assign acc[j+1]  = acc[j] + row_v[j];
    end

    assign prod = acc[W];
endmodule

// File: rtl/mul_outstage.sv
module mul_outstage
    import mul_pkg::*;
#(
    parameter int PW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] prod_in,
    output logic          out_valid,
    output logic [PW-1:0] prod_out
);
    if (REG_OUT) begin : g_reg
        out_state_t state_q, state_d;
        logic [PW-1:0] prod_q;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
                ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= ST_IDLE;
            else        state_q <= state_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        prod_q <= '0;
            else if (in_valid) prod_q <= prod_in;
        end

        always_comb begin
            out_valid = (state_q == ST_VALID);
            prod_out  = prod_q;
        end

        // R5: valid follows accepted input by one cycle
        a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R5: no valid without a preceding accepted input
        a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R6: product held while idle
        a_r6_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(prod_out));
    end else begin : g_comb
        always_comb begin
            out_valid = in_valid;
            prod_out  = prod_in;
        end
    end
endmodule

// File: rtl/prec_scalable_mul.sv
module prec_scalable_mul
    import mul_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              half_prec,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);
    localparam int LOW_W = OP_W / 2;

    logic [OP_W-1:0]   a_gated, b_gated;
    logic [PROD_W-1:0] raw_prod;

    mul_opgate #(.W(OP_W)) i_gate_a (
        .half_prec (half_prec),
        .op_in     (op_a),
        .op_out    (a_gated)
    );

    mul_opgate #(.W(OP_W)) i_gate_b (
        .half_prec (half_prec),
        .op_in     (op_b),
        .op_out    (b_gated)
    );

    mul_bw_array #(.W(OP_W)) i_array (
        .mcand  (a_gated),
        .mplier (b_gated),
        .prod   (raw_prod)
    );

    mul_outstage #(.PW(PROD_W), .REG_OUT(REG_OUT)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .prod_in   (raw_prod),
        .out_valid (out_valid),
        .prod_out  (product)
    );

    if (REG_OUT) begin : g_chk
        logic signed [PROD_W-1:0] ref_full;
        always_comb ref_full = PROD_W'($signed(op_a) * $signed(op_b));

        // R1: full-precision result matches a signed reference product
        a_r1_full_product: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !half_prec) |=> (product == $past(ref_full)));
        // R2: low half of a reduced-precision result is zero
        a_r2_half_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && half_prec) |=> (product[2*LOW_W-1:0] == '0));
    end
endmodule

// File: tb/test_prec_scalable_mul.sv
module test_prec_scalable_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        half_prec = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        out_valid;
    logic [31:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prec_scalable_mul #(.REG_OUT(1'b1)) i_prec_scalable_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_prec(half_prec),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
    );

    function automatic logic [31:0] expect_prod(logic [15:0] a, logic [15:0] b, logic h);
        logic signed [31:0] sa, sb;
        if (h) begin
            sa = 32'($signed(a[15:8]));
            sb = 32'($signed(b[15:8]));
            return 32'((sa * sb) <<< 16);
        end
        sa = 32'($signed(a));
        sb = 32'($signed(b));
        return 32'(sa * sb);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One accepted operation; checks valid and product on the next cycle.
    task automatic run_op(string req, logic [15:0] a, logic [15:0] b, logic h);
        @(negedge clk);
        op_a = a; op_b = b; half_prec = h; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, product, expect_prod(a, b, h));
        @(negedge clk);
        check({req, " valid drop R5"}, 32'(out_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 out_valid", 32'(out_valid), 32'd0);
        check("R7 product", product, 32'd0);
    endtask

    task automatic t_full();
        run_op("R1 pos", 16'd1234, 16'd567, 1'b0);
        run_op("R1 large", 16'h7FFF, 16'h7FFF, 1'b0);
        run_op("R8 mixed", 16'hFF38, 16'd300, 1'b0);
        run_op("R8 zero", 16'd0, 16'h8000, 1'b0);
        run_op("R8 unit", 16'hFFFF, 16'h1234, 1'b0);
    endtask

    task automatic t_half();
        run_op("R2 pos", 16'h05A7, 16'h093C, 1'b1);
        run_op("R2 mixed", 16'hF9FF, 16'h1181, 1'b1);
        run_op("R8 half neg", 16'h80AA, 16'h7F55, 1'b1);
        // R2: low bytes differ, result must match the zero-low-byte case
        run_op("R2 lowbytes", 16'h0AFF, 16'h0BFF, 1'b1);
        check("R2 lowbytes value", product, 32'h006E0000);
    endtask

    task automatic t_extreme();
        run_op("R3 full", 16'h8000, 16'h8000, 1'b0);
        check("R3 full const", product, 32'h40000000);
        run_op("R3 half", 16'h8011, 16'h8022, 1'b1);
        check("R3 half const", product, 32'h40000000);
    endtask

    task automatic t_alternate();
        @(negedge clk);
        op_a = 16'h1234; op_b = 16'h5678; half_prec = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R4 first", product, expect_prod(16'h1234, 16'h5678, 1'b0));
        op_a = 16'h1234; op_b = 16'h5678; half_prec = 1'b1;
        @(negedge clk);
        check("R4 second", product, expect_prod(16'h1234, 16'h5678, 1'b1));
        check("R4 valid", 32'(out_valid), 32'd1);
        op_a = 16'hC3A5; op_b = 16'h0F0F; half_prec = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 third", product, expect_prod(16'hC3A5, 16'h0F0F, 1'b0));
    endtask

    task automatic t_hold();
        logic [31:0] kept;
        @(negedge clk);
        kept = product;
        for (int k = 0; k < 4; k++) begin
            op_a = 16'(k * 16'h1111 + 7); op_b = 16'hABCD ^ 16'(k);
            half_prec = k[0];
            @(negedge clk);
            check("R6 hold", product, kept);
            check("R6 no valid R5", 32'(out_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_half();
        t_extreme();
        t_alternate();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule